// File: doc/BRIEF.md
# MSI Snooping Coherence Controller

This block is the coherence controller that sits beside one write-back data cache on a shared broadcast bus. It holds, for every line of a small direct-mapped tag array, a tag and one of three line states: Invalid (no copy), Shared (clean copy that other caches may also hold) or Modified (the only copy, dirty). The protocol keeps the single-writer rule: a line is either held read-only in any number of caches or held read/write in exactly one.

Processor requests arrive on a valid/ready port as read, write or evict (replacement) operations. A request that the local state can satisfy completes in the same cycle. Any other request raises a bus request carrying a command and a line address. The request stays stalled until a grant arrives, and the line state changes at the end of the grant cycle. A snoop port carries the bus-read and bus-write events of other caches. Whenever this cache holds the dirty copy that such an event needs, the block pulses a data-supply strobe with the line address, in the same cycle. The same strobe marks the cycle in which a dirty line is written back to memory.

Line-state transitions, named as they appear in the RTL: I→S on a granted fetch for read (BC_RD), I→M on a granted fetch for write (BC_WR), S→M on a granted upgrade (BC_UPG), M→I on a granted writeback (BC_WB), S→I on a silent evict or a snooped bus-write, M→S on a snooped bus-read, and M→I on a snooped bus-write. The local request decoder picks one action per cycle: ACT_IDLE, ACT_HIT, ACT_DROP, ACT_FETCH_S, ACT_FETCH_M, ACT_UPGRADE, ACT_FLUSH or ACT_VICTIM. A two-state phase register (PH_IDLE, PH_WAIT) records whether a bus request is outstanding.

Top module: `msi_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid, so the first read to any address raises bus_req with bus_cmd 1 (fetch for read). The address bits split as {tag, index}, with the index in the low INDEX_W bits.
- R2: A read that misses raises bus_req with bus_cmd 1 and bus_addr equal to cpu_addr, and holds it until bus_gnt. cpu_ready is high only in the grant cycle, after which the line is Shared with the new tag.
- R3: A write that misses raises bus_cmd 2 (fetch for write). In the grant cycle cpu_ready is high, and the line becomes Modified.
- R4: A write that hits a Shared line raises bus_cmd 3 (upgrade/invalidate). In the grant cycle cpu_ready is high, and the line becomes Modified.
- R5: A read that hits in Shared or Modified, or a write that hits in Modified, gives cpu_ready in the same cycle with no bus request and no state change.
- R6: A snoop with snp_cmd 0 (bus-read) that hits a Modified line pulses sd_valid in that cycle with sd_addr equal to snp_addr, and the line becomes Shared. A Shared line ignores it.
- R7: A snoop with snp_cmd 1 (bus-write) that hits a Modified line pulses sd_valid with sd_addr equal to snp_addr and the line becomes Invalid. A hit on a Shared line moves it to Invalid without sd_valid.
- R8: cpu_op 2 (evict) on a Modified hit raises bus_cmd 4 (writeback). In the grant cycle it gives sd_valid with sd_addr equal to the line address, gives cpu_ready, and moves the line to Invalid. On a Shared hit the line goes to Invalid with cpu_ready at once and no bus traffic. On a miss it completes at once with no effect.
- R9: A read or write whose index holds a Modified line with a different tag first raises bus_cmd 4 with bus_addr built from the resident tag. In that grant cycle it gives sd_valid but not cpu_ready, and the victim becomes Invalid. The original request then proceeds as a miss.
- R10: When a snoop targets the same index as a valid local request, or when a snoop needs sd_valid, the local request raises neither bus_req nor cpu_ready in that cycle. The snoop is applied, and the local request is evaluated again in the next cycle.
- R11: cpu_op 3 is a no-operation. It gives cpu_ready at once and causes no bus traffic and no state change.
- R12: bus_gnt while bus_req is low changes no state and produces no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_valid | input | 1 | Processor request present (held until cpu_ready) |
| cpu_op | input | 2 | 0 read, 1 write, 2 evict, 3 no-op |
| cpu_addr | input | ADDR_W | Line address of the request |
| cpu_ready | output | 1 | Request completes this cycle |
| bus_req | output | 1 | Bus request |
| bus_cmd | output | 3 | 0 none, 1 fetch-read, 2 fetch-write, 3 upgrade, 4 writeback |
| bus_addr | output | ADDR_W | Line address of the bus command (0 when idle) |
| bus_gnt | input | 1 | Bus grant for the current request |
| snp_valid | input | 1 | Snooped event from another cache |
| snp_cmd | input | 1 | 0 bus-read, 1 bus-write |
| snp_addr | input | ADDR_W | Line address of the snooped event |
| sd_valid | output | 1 | This cache supplies dirty data this cycle |
| sd_addr | output | ADDR_W | Line address of the supplied data (0 when idle) |

## Verification
The bench targets the cycles where a snoop and a local request meet. A design that let a same-index snoop through would upgrade a line that the snoop had just invalidated, so it would issue bus_cmd 3 where bus_cmd 2 is due and report a line as held that is not. Dirty-victim replacement is driven on purpose: a controller that skipped the writeback would lose the Modified data silently, and one that raised cpu_ready on the victim grant would complete the read before the line was fetched. Grants are withheld for several cycles and also raised while no request is pending, which exposes state that changes too early or on a stray grant.

// File: rtl/msi_pkg.sv
package msi_pkg;

    typedef enum logic [1:0] {
        LS_I = 2'd0,
        LS_S = 2'd1,
        LS_M = 2'd2
    } line_st_t;

    typedef enum logic [1:0] {
        OP_RD    = 2'd0,
        OP_WR    = 2'd1,
        OP_EVICT = 2'd2,
        OP_NOP   = 2'd3
    } cpu_op_t;

    typedef enum logic [2:0] {
        BC_NONE = 3'd0,
        BC_RD   = 3'd1,
        BC_WR   = 3'd2,
        BC_UPG  = 3'd3,
        BC_WB   = 3'd4
    } bus_cmd_t;

    typedef enum logic [2:0] {
        ACT_IDLE,
        ACT_HIT,
        ACT_DROP,
        ACT_FETCH_S,
        ACT_FETCH_M,
        ACT_UPGRADE,
        ACT_FLUSH,
        ACT_VICTIM
    } act_t;

    typedef enum logic {
        PH_IDLE,
        PH_WAIT
    } phase_t;

endpackage

// File: rtl/msi_tag_store.sv
module msi_tag_store
    import msi_pkg::*;
#(
    parameter int INDEX_W = 3,
    parameter int TAG_W   = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [INDEX_W-1:0] a_idx,
    output line_st_t           a_st,
    output logic [TAG_W-1:0]   a_tag,
    input  logic               a_we,
    input  line_st_t           a_st_nx,
    input  logic [TAG_W-1:0]   a_tag_nx,
    input  logic [INDEX_W-1:0] b_idx,
    output line_st_t           b_st,
    output logic [TAG_W-1:0]   b_tag,
    input  logic               b_we,
    input  line_st_t           b_st_nx
);
    localparam int LINES = 1 << INDEX_W;

    line_st_t         st_arr  [LINES];
    logic [TAG_W-1:0] tag_arr [LINES];

    for (genvar e = 0; e < LINES; e++) begin : g_line
        line_st_t         st_q;
        logic [TAG_W-1:0] tag_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                st_q  <= LS_I;
                tag_q <= '0;
            end else if (a_we && a_idx == INDEX_W'(e)) begin
                st_q  <= a_st_nx;
                tag_q <= a_tag_nx;
            end else if (b_we && b_idx == INDEX_W'(e)) begin
                st_q  <= b_st_nx;
            end
        end

        assign st_arr[e]  = st_q;
        assign tag_arr[e] = tag_q;
    end

    assign a_st  = st_arr[a_idx];
    assign a_tag = tag_arr[a_idx];
    assign b_st  = st_arr[b_idx];
    assign b_tag = tag_arr[b_idx];

    AST_PORTS_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
        (a_we && b_we) |-> (a_idx != b_idx)); // R10

endmodule

// File: rtl/msi_snoop_unit.sv
module msi_snoop_unit
    import msi_pkg::*;
#(
    parameter int TAG_W = 7
) (
    input  logic             snp_valid,
    input  logic             snp_cmd,
    input  logic [TAG_W-1:0] snp_tag,
    input  line_st_t         line_st,
    input  logic [TAG_W-1:0] line_tag,
    output logic             supply,
    output logic             we,
    output line_st_t         st_nx
);
    logic hit;

    always_comb begin
        hit    = snp_valid && (line_st != LS_I) && (line_tag == snp_tag);
        supply = 1'b0;
        we     = 1'b0;
        st_nx  = line_st;
        if (hit) begin
            unique case (line_st)
                LS_M: begin
                    supply = 1'b1;
                    we     = 1'b1;
                    st_nx  = snp_cmd ? LS_I : LS_S;
                end
                LS_S: begin
                    if (snp_cmd) begin
                        we    = 1'b1;
                        st_nx = LS_I;
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/msi_local_ctrl.sv
module msi_local_ctrl
    import msi_pkg::*;
#(
    parameter int INDEX_W = 3,
    parameter int TAG_W   = 7
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cpu_valid,
    input  logic [1:0]               cpu_op,
    input  logic [TAG_W-1:0]         req_tag,
    input  logic [INDEX_W-1:0]       req_idx,
    input  line_st_t                 line_st,
    input  logic [TAG_W-1:0]         line_tag,
    input  logic                     blocked,
    input  logic                     bus_gnt,
    output logic                     cpu_ready,
    output logic                     bus_req,
    output bus_cmd_t                 bus_cmd,
    output logic [TAG_W+INDEX_W-1:0] bus_addr,
    output logic                     line_we,
    output line_st_t                 st_nx,
    output logic [TAG_W-1:0]         tag_nx,
    output logic                     wb_supply
);
    act_t   act;
    phase_t phase_q, phase_d;
    logic   hit, dirty_victim;

    // Action decode: one action per cycle from the request and the line state
    always_comb begin
        hit          = (line_st != LS_I) && (line_tag == req_tag);
        dirty_victim = (line_st == LS_M) && !hit;
        act          = ACT_IDLE;
        if (cpu_valid && !blocked) begin
            unique case (cpu_op_t'(cpu_op))
                OP_RD:    act = hit ? ACT_HIT : (dirty_victim ? ACT_VICTIM : ACT_FETCH_S);
                OP_WR:    act = (hit && line_st == LS_M) ? ACT_HIT :
                                hit ? ACT_UPGRADE :
                                dirty_victim ? ACT_VICTIM : ACT_FETCH_M;
                OP_EVICT: act = !hit ? ACT_HIT : ((line_st == LS_M) ? ACT_FLUSH : ACT_DROP);
                OP_NOP:   act = ACT_HIT;
            endcase
        end
    end

    // Output and line-update decode
    always_comb begin
        cpu_ready = 1'b0;
        bus_req   = 1'b0;
        bus_cmd   = BC_NONE;
        bus_addr  = '0;
        line_we   = 1'b0;
        st_nx     = line_st;
        tag_nx    = line_tag;
        wb_supply = 1'b0;
        unique case (act)
            ACT_IDLE: ;
            ACT_HIT:  cpu_ready = 1'b1;
            ACT_DROP: begin
                cpu_ready = 1'b1;
                line_we   = 1'b1;
                st_nx     = LS_I;
            end
            ACT_FETCH_S, ACT_FETCH_M, ACT_UPGRADE: begin
                bus_req  = 1'b1;
                bus_cmd  = (act == ACT_FETCH_S) ? BC_RD :
                           (act == ACT_FETCH_M) ? BC_WR : BC_UPG;
                bus_addr = {req_tag, req_idx};
                if (bus_gnt) begin
                    cpu_ready = 1'b1;
                    line_we   = 1'b1;
                    st_nx     = (act == ACT_FETCH_S) ? LS_S : LS_M;
                    tag_nx    = req_tag;
                end
            end
            ACT_FLUSH, ACT_VICTIM: begin
                bus_req  = 1'b1;
                bus_cmd  = BC_WB;
                bus_addr = {line_tag, req_idx};
                if (bus_gnt) begin
                    cpu_ready = (act == ACT_FLUSH);
                    wb_supply = 1'b1;
                    line_we   = 1'b1;
                    st_nx     = LS_I;
                end
            end
        endcase
    end

    // Phase register: records an outstanding ungranted bus request
    always_comb phase_d = (bus_req && !bus_gnt) ? PH_WAIT : PH_IDLE;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase_q <= PH_IDLE;
        else        phase_q <= phase_d;
    end

    AST_READY_IN_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ready && bus_req) |-> bus_gnt); // R2

    AST_WAIT_KEEPS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_WAIT && cpu_valid && !blocked) |-> bus_req); // R2

    AST_WB_ONLY_GRANTED: assert property (@(posedge clk) disable iff (!rst_n)
        wb_supply |-> (bus_gnt && bus_cmd == BC_WB)); // R8

endmodule

// File: rtl/msi_snoop_ctrl.sv
module msi_snoop_ctrl
    import msi_pkg::*;
#(
    parameter int ADDR_W  = 10,
    parameter int INDEX_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_valid,
    input  logic [1:0]        cpu_op,
    input  logic [ADDR_W-1:0] cpu_addr,
    output logic              cpu_ready,
    output logic              bus_req,
    output logic [2:0]        bus_cmd,
    output logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_gnt,
    input  logic              snp_valid,
    input  logic              snp_cmd,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              sd_valid,
    output logic [ADDR_W-1:0] sd_addr
);
    localparam int TAG_W = ADDR_W - INDEX_W;

    logic [INDEX_W-1:0] cpu_idx, snp_idx;
    logic [TAG_W-1:0]   cpu_tag, snp_tag;
    line_st_t           loc_st, snp_st, loc_st_nx, snp_st_nx;
    logic [TAG_W-1:0]   loc_tag, snp_line_tag, loc_tag_nx;
    logic               loc_we, snp_we, snp_supply, wb_supply, blocked;
    bus_cmd_t           cmd;

    assign cpu_idx = cpu_addr[INDEX_W-1:0];
    assign cpu_tag = cpu_addr[ADDR_W-1:INDEX_W];
    assign snp_idx = snp_addr[INDEX_W-1:0];
    assign snp_tag = snp_addr[ADDR_W-1:INDEX_W];

    msi_tag_store #(.INDEX_W(INDEX_W), .TAG_W(TAG_W)) i_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .a_idx    (cpu_idx),
        .a_st     (loc_st),
        .a_tag    (loc_tag),
        .a_we     (loc_we),
        .a_st_nx  (loc_st_nx),
        .a_tag_nx (loc_tag_nx),
        .b_idx    (snp_idx),
        .b_st     (snp_st),
        .b_tag    (snp_line_tag),
        .b_we     (snp_we),
        .b_st_nx  (snp_st_nx)
    );

    msi_snoop_unit #(.TAG_W(TAG_W)) i_snoop (
        .snp_valid (snp_valid),
        .snp_cmd   (snp_cmd),
        .snp_tag   (snp_tag),
        .line_st   (snp_st),
        .line_tag  (snp_line_tag),
        .supply    (snp_supply),
        .we        (snp_we),
        .st_nx     (snp_st_nx)
    );

    // Snoop wins on a shared index or when it owns the data-supply strobe
    assign blocked = snp_valid && ((snp_idx == cpu_idx) || snp_supply);

    msi_local_ctrl #(.INDEX_W(INDEX_W), .TAG_W(TAG_W)) i_local (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_valid (cpu_valid),
        .cpu_op    (cpu_op),
        .req_tag   (cpu_tag),
        .req_idx   (cpu_idx),
        .line_st   (loc_st),
        .line_tag  (loc_tag),
        .blocked   (blocked),
        .bus_gnt   (bus_gnt),
        .cpu_ready (cpu_ready),
        .bus_req   (bus_req),
        .bus_cmd   (cmd),
        .bus_addr  (bus_addr),
        .line_we   (loc_we),
        .st_nx     (loc_st_nx),
        .tag_nx    (loc_tag_nx),
        .wb_supply (wb_supply)
    );

    assign bus_cmd  = cmd;
    assign sd_valid = snp_supply | wb_supply;
    assign sd_addr  = snp_supply ? snp_addr : (wb_supply ? bus_addr : '0);

    AST_ONE_SUPPLIER: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({snp_supply, wb_supply})); // R10

    AST_COLLIDE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_valid && snp_valid && snp_idx == cpu_idx) |-> (!cpu_ready && !bus_req)); // R10

    AST_UPG_FROM_SHARED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && cmd == BC_UPG) |-> (loc_st == LS_S && loc_tag == cpu_tag)); // R4

    AST_SNP_DIRTY_LEAVES_M: assert property (@(posedge clk) disable iff (!rst_n)
        snp_supply |=> (snp_st != LS_M || !$stable(snp_addr) || loc_we)); // R6

endmodule

// File: tb/test_msi_snoop_ctrl.sv
`timescale 1ns/1ps
module test_msi_snoop_ctrl;
    localparam int AW = 10;
    localparam int IW = 3;
    localparam int NL = 1 << IW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cpu_valid = 1'b0;
    logic [1:0]    cpu_op = 2'd0;
    logic [AW-1:0] cpu_addr = '0;
    logic          bus_gnt = 1'b0;
    logic          snp_valid = 1'b0;
    logic          snp_cmd = 1'b0;
    logic [AW-1:0] snp_addr = '0;
    logic          cpu_ready, bus_req, sd_valid;
    logic [2:0]    bus_cmd;
    logic [AW-1:0] bus_addr, sd_addr;

    always #2.5 clk = ~clk;

    msi_snoop_ctrl #(.ADDR_W(AW), .INDEX_W(IW)) i_msi_snoop_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cpu_valid(cpu_valid), .cpu_op(cpu_op), .cpu_addr(cpu_addr), .cpu_ready(cpu_ready),
        .bus_req(bus_req), .bus_cmd(bus_cmd), .bus_addr(bus_addr), .bus_gnt(bus_gnt),
        .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
        .sd_valid(sd_valid), .sd_addr(sd_addr)
    );

    // Reference model: 0 Invalid, 1 Shared, 2 Modified
    int mst [NL];
    int mtag[NL];
    int vectors = 0;
    int errors  = 0;
    bit e_ready, e_req, e_sd;
    int e_cmd, e_addr, e_sda;
    bit lw, sw;
    int lidx, lst, ltag, sidx_p, sst;
    string why;

    task automatic model_eval();
        int idx  = int'(cpu_addr) % NL;
        int tg   = int'(cpu_addr) / NL;
        int sidx = int'(snp_addr) % NL;
        int stg  = int'(snp_addr) / NL;
        bit shit, ssup, hit, dv;
        int need, baddr, nst, ntag;
        bit rdy_g, wb_g;
        e_ready = 0; e_req = 0; e_sd = 0; e_cmd = 0; e_addr = 0; e_sda = 0;
        lw = 0; sw = 0; why = "";
        need = 0; baddr = 0; nst = 0; ntag = 0; rdy_g = 0; wb_g = 0;
        shit = snp_valid && mst[sidx] != 0 && mtag[sidx] == stg;
        ssup = shit && mst[sidx] == 2;
        sidx_p = sidx;
        if (snp_valid) why = snp_cmd ? "R7" : "R6";
        if (shit) begin
            if (mst[sidx] == 2) begin
                sw = 1; sst = snp_cmd ? 0 : 1; e_sd = 1; e_sda = int'(snp_addr);
            end else if (snp_cmd) begin
                sw = 1; sst = 0;
            end
        end
        if (cpu_valid && snp_valid && (sidx == idx || ssup)) begin
            why = {why, " R10"};
        end else if (cpu_valid) begin
            hit = mst[idx] != 0 && mtag[idx] == tg;
            dv  = mst[idx] == 2 && !hit;
            case (cpu_op)
                2'd0: begin
                    if (hit) begin e_ready = 1; why = {why, " R5"}; end
                    else if (dv) begin need = 4; baddr = mtag[idx]*NL + idx; nst = 0; ntag = mtag[idx]; wb_g = 1; why = {why, " R9"}; end
                    else begin need = 1; baddr = int'(cpu_addr); nst = 1; ntag = tg; rdy_g = 1; why = {why, " R2"}; end
                end
                2'd1: begin
                    if (hit && mst[idx] == 2) begin e_ready = 1; why = {why, " R5"}; end
                    else if (hit) begin need = 3; baddr = int'(cpu_addr); nst = 2; ntag = tg; rdy_g = 1; why = {why, " R4"}; end
                    else if (dv) begin need = 4; baddr = mtag[idx]*NL + idx; nst = 0; ntag = mtag[idx]; wb_g = 1; why = {why, " R9"}; end
                    else begin need = 2; baddr = int'(cpu_addr); nst = 2; ntag = tg; rdy_g = 1; why = {why, " R3"}; end
                end
                2'd2: begin
                    why = {why, " R8"};
                    if (!hit) e_ready = 1;
                    else if (mst[idx] == 2) begin need = 4; baddr = int'(cpu_addr); nst = 0; ntag = tg; rdy_g = 1; wb_g = 1; end
                    else begin e_ready = 1; lw = 1; lidx = idx; lst = 0; ltag = mtag[idx]; end
                end
                default: begin e_ready = 1; why = {why, " R11"}; end
            endcase
            if (need != 0) begin
                e_req = 1; e_cmd = need; e_addr = baddr;
                if (bus_gnt) begin
                    e_ready = rdy_g;
                    if (wb_g) begin e_sd = 1; e_sda = baddr; end
                    lw = 1; lidx = idx; lst = nst; ltag = ntag;
                end
            end
        end
        if (why == "") why = bus_gnt ? "R12" : "R1";
    endtask

    task automatic cyc(input bit v, input int op, input int addr, input bit g,
                       input bit sv, input bit sc, input int sa, input string ctx);
        @(negedge clk);
        cpu_valid = v; cpu_op = op[1:0]; cpu_addr = AW'(addr); bus_gnt = g;
        snp_valid = sv; snp_cmd = sc; snp_addr = AW'(sa);
        #1;
        model_eval();
        vectors++;
        if (cpu_ready !== e_ready || bus_req !== e_req || int'(bus_cmd) != e_cmd ||
            int'(bus_addr) != e_addr || sd_valid !== e_sd || int'(sd_addr) != e_sda) begin
            errors++;
            $display("FAIL %s %s: got rdy=%0d req=%0d cmd=%0d baddr=%0h sd=%0d sda=%0h exp rdy=%0d req=%0d cmd=%0d baddr=%0h sd=%0d sda=%0h",
                     why, ctx, cpu_ready, bus_req, bus_cmd, bus_addr, sd_valid, sd_addr,
                     e_ready, e_req, e_cmd, e_addr, e_sd, e_sda);
        end
        @(posedge clk);
        if (sw) mst[sidx_p] = sst;
        if (lw) begin mst[lidx] = lst; mtag[lidx] = ltag; end
    endtask

    // Hold a request until the model says it completes; grant after gdelay cycles
    task automatic req(input int op, input int addr, input int gdelay, input string ctx);
        for (int k = 0; k < 40; k++) begin
            cyc(1, op, addr, k >= gdelay, 0, 0, 0, ctx);
            if (e_ready) break;
        end
    endtask

    task automatic snoop(input bit sc, input int sa, input string ctx);
        cyc(0, 0, 0, 0, 1, sc, sa, ctx);
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < NL; i++) begin mst[i] = 0; mtag[i] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset state, every index misses
        for (int i = 0; i < NL; i++) cyc(1, 0, 8*i + i, 0, 0, 0, 0, "R1 reset read");
        cyc(0, 0, 0, 1, 0, 0, 0, "R12 stray grant");

        req(0, 'h05, 2, "R2 read miss");
        req(0, 'h05, 0, "R5 read hit S");
        req(1, 'h05, 1, "R4 upgrade");
        req(1, 'h05, 0, "R5 write hit M");
        snoop(0, 'h05, "R6 busrd on M");
        snoop(0, 'h05, "R6 busrd on S");
        snoop(1, 'h05, "R7 buswr on S");
        req(0, 'h05, 0, "R2 refetch");
        req(1, 'h0A, 1, "R3 write miss");
        snoop(1, 'h0A, "R7 buswr on M");
        req(1, 'h0A, 0, "R3 write miss again");
        req(0, 'h12, 2, "R9 dirty victim");
        req(2, 'h12, 0, "R8 evict S");
        req(2, 'h12, 0, "R8 evict miss");
        req(1, 'h13, 0, "R3 setup");
        req(2, 'h13, 2, "R8 evict M");
        cyc(1, 0, 'h04, 1, 1, 0, 'h0C, "R10 same index");
        req(0, 'h04, 0, "R2 after collision");
        req(1, 'h06, 0, "R3 setup");
        cyc(1, 0, 'h01, 1, 1, 0, 'h06, "R10 supply blocks");
        req(0, 'h01, 0, "R2 after block");
        req(3, 'h07, 0, "R11 nop");
        cyc(0, 0, 0, 1, 0, 0, 0, "R12 stray grant");

        // Mixed traffic on a small address set
        begin
            bit hold = 0;
            int op = 0, addr = 0;
            for (int n = 0; n < 4000; n++) begin
                bit sv = ($urandom % 4) == 0;
                if (!hold) begin
                    op   = $urandom % 4;
                    addr = ($urandom % 3) * NL + ($urandom % 4);
                end
                hold = ($urandom % 5) != 0 || hold;
                cyc(hold, op, addr, ($urandom % 2) == 0, sv, $urandom % 2,
                    ($urandom % 3) * NL + ($urandom % 4), "mixed");
                if (e_ready) hold = 0;
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule